// File: doc/BRIEF.md
# Serial Register-Pointer Target for a Four-Pin Port Expander

This block is the two-wire serial bus target of a small general-purpose port expander. It watches oversampled clock and data lines in the system clock domain and answers only to one fixed 7-bit address. In a write transfer, the first byte after the address is a command byte. That byte loads an 8-bit pointer, and each later byte is written to the register the pointer selects. Reading uses a write of the address and command byte, a repeated START, and then the address with the read bit set. From then on, data bytes are shifted out until the controller declines one.

The pointer never advances by itself. Every read and every write goes to the register last named, across transfers, until a new command byte arrives. The block holds three writable 8-bit registers: output levels, input polarity inversion, and pin direction. It also forms the read-only input value from the pin levels. Every access is presented on a register-port interface: pointer, one-cycle write strobe, write data and read strobe. The open-drain data line is modelled by a pull-low enable.

Top module: `gpx_i2c_target`

## Requirements
- R1: The target answers only to address 1001001 (address byte bits 7..1, R/W in bit 0, 0 = write, 1 = read). A match is acknowledged by pulling SDA low for the ninth clock. Any other address gets no acknowledge, and the target then ignores the bus, acknowledging nothing and writing nothing, until the next START.
- R2: The first byte after a write-address byte is acknowledged and becomes the pointer. It produces no write strobe.
- R3: Each further byte of the same write transfer is acknowledged and overwrites the selected register, with exactly one single-cycle write strobe per byte.
- R4: Pointer 0 selects the read-only input value. Bytes written to it are acknowledged but change none of the registers.
- R5: Pointer values above 3 are acknowledged. Writes through them change nothing, and reads through them return FFh.
- R6: The pointer never increments. All bytes of one read come from the same register, and a later read transfer with no new command byte reads that register again.
- R7: Read data goes out MSB first, changing only while SCL is low. A controller acknowledge (SDA low on the ninth clock) fetches the next byte. A no-acknowledge ends the output, and SDA stays released.
- R8: Reading pointer 0 returns bits 3..0 = pin level XOR polarity register bits 3..0, with bits 7..4 read as 1.
- R9: A STOP at any bit position ends the transfer and releases SDA. A byte cut short by STOP writes nothing, and the next transfer is handled normally.
- R10: While reset is low and after it is released: output register FFh, polarity 00h, direction FFh, pointer 0, SDA released. A reset in the middle of a transfer also restores these values.
- R11: SCL and SDA pass through two synchronising flops. SDA falling while SCL is high is a START, or a repeated START at any point, and restarts address reception without writing a partial byte. SDA rising while SCL is high is a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pin_lvl | input | 4 | Current levels of the four port pins |
| out_reg | output | 8 | Output level register |
| pol_reg | output | 8 | Input polarity inversion register |
| cfg_reg | output | 8 | Direction register (1 = input) |
| rp_addr | output | 8 | Register pointer |
| rp_wr | output | 1 | One-cycle write strobe |
| rp_wdata | output | 8 | Data of the last write strobe |
| rp_rd | output | 1 | One-cycle read strobe when a byte is loaded for sending |

## Verification
A wrong bit counter or state shows up at the ninth clock of the affected byte: the acknowledge is missing, or it lands a bit early or late. That is at most nine SCL periods after the fault. A corrupted pointer first shows up at the next data byte, either as a register changing where the model expects none, or as a wrong read byte. A late or missing START or STOP decode leaves SDA driven, or the target deaf, for the whole next transfer. Register contents are compared with the model on every clock outside a short settling window after each SCL edge, so a stray write is visible within a few cycles.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_CMD,
    ST_CACK,
    ST_WDAT,
    ST_WACK,
    ST_TX,
    ST_TACK
  } gpx_state_e;

  localparam int REG_IN  = 0;
  localparam int REG_OUT = 1;
  localparam int REG_POL = 2;
  localparam int REG_CFG = 3;
endpackage

// File: rtl/gpx_bus_sync.sv
module gpx_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  always_comb begin
    scl_s     = scl_pipe[SYNC_STAGES-1];
    sda_s     = sda_pipe[SYNC_STAGES-1];
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    start_det = scl_s & scl_d & sda_d & ~sda_s;
    stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  end
endmodule

// File: rtl/gpx_i2c_fsm.sv
module gpx_i2c_fsm
  import gpx_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'b1001001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rp_rdata,
  output logic          sda_oe,
  output logic [DW-1:0] rp_addr,
  output logic          rp_wr,
  output logic [DW-1:0] rp_wdata,
  output logic          rp_rd
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

  gpx_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [DW-1:0]    sh, sh_n, ptr, ptr_n, wdat, wdat_n;
  logic             rw, rw_n, nack, nack_n, oe, oe_n, wr, wr_n, rd;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sh_n    = sh;
    ptr_n   = ptr;
    wdat_n  = wdat;
    rw_n    = rw;
    nack_n  = nack;
    oe_n    = oe;
    wr_n    = 1'b0;
    rd      = 1'b0;
    if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_WDAT: begin
          if (scl_rise && cnt != CNT_FULL) begin
            sh_n  = {sh[DW-2:0], sda_s};
            cnt_n = cnt + CNT_W'(1);
          end else if (scl_fall && cnt == CNT_FULL) begin
            cnt_n = '0;
            if (state == ST_ADDR) begin
              if (sh[DW-1:1] == DEV_ADDR) begin
                rw_n    = sh[0];
                oe_n    = 1'b1;
                state_n = ST_AACK;
              end else begin
                state_n = ST_IDLE;
              end
            end else if (state == ST_CMD) begin
              ptr_n   = sh;
              oe_n    = 1'b1;
              state_n = ST_CACK;
            end else begin
              wr_n    = 1'b1;
              wdat_n  = sh;
              oe_n    = 1'b1;
              state_n = ST_WACK;
            end
          end
        end
        ST_AACK, ST_CACK, ST_WACK: begin
          if (scl_fall) begin
            oe_n = 1'b0;
            if (state == ST_AACK && rw) begin
              rd      = 1'b1;
              sh_n    = rp_rdata;
              oe_n    = ~rp_rdata[DW-1];
              state_n = ST_TX;
            end else if (state == ST_AACK) begin
              state_n = ST_CMD;
            end else begin
              state_n = ST_WDAT;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == CNT_LAST) begin
              oe_n    = 1'b0;
              cnt_n   = '0;
              state_n = ST_TACK;
            end else begin
              sh_n  = {sh[DW-2:0], 1'b0};
              oe_n  = ~sh[DW-2];
              cnt_n = cnt + CNT_W'(1);
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            nack_n = sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              state_n = ST_IDLE;
            end else begin
              rd      = 1'b1;
              sh_n    = rp_rdata;
              oe_n    = ~rp_rdata[DW-1];
              state_n = ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= '0;
      wdat  <= '0;
      rw    <= 1'b0;
      nack  <= 1'b1;
      oe    <= 1'b0;
      wr    <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      sh    <= sh_n;
      ptr   <= ptr_n;
      wdat  <= wdat_n;
      rw    <= rw_n;
      nack  <= nack_n;
      oe    <= oe_n;
      wr    <= wr_n;
    end
  end

  assign sda_oe   = oe;
  assign rp_addr  = ptr;
  assign rp_wr    = wr;
  assign rp_wdata = wdat;
  assign rp_rd    = rd;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe);
  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_wr |=> !rp_wr);
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe));
  // R11
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && !sda_oe));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic [DW-1:0]    addr,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    out_q,
  output logic [DW-1:0]    pol_q,
  output logic [DW-1:0]    cfg_q
);
  localparam logic [DW-1:0] A_IN  = DW'(REG_IN);
  localparam logic [DW-1:0] A_OUT = DW'(REG_OUT);
  localparam logic [DW-1:0] A_POL = DW'(REG_POL);
  localparam logic [DW-1:0] A_CFG = DW'(REG_CFG);

  logic [DW-1:0] out_n, pol_n, cfg_n, in_val;

  generate
    if (DW > NPINS) begin : g_pad
      assign in_val = {{(DW-NPINS){1'b1}}, pin_lvl ^ pol_q[NPINS-1:0]};
    end else begin : g_nopad
      assign in_val = pin_lvl ^ pol_q[NPINS-1:0];
    end
  endgenerate

  always_comb begin
    out_n = out_q;
    pol_n = pol_q;
    cfg_n = cfg_q;
    if (wr) begin
      if (addr == A_OUT) out_n = wdata;
      if (addr == A_POL) pol_n = wdata;
      if (addr == A_CFG) cfg_n = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else begin
      out_q <= out_n;
      pol_q <= pol_n;
      cfg_q <= cfg_n;
    end
  end

  always_comb begin
    if (addr == A_IN)       rdata = in_val;
    else if (addr == A_OUT) rdata = out_q;
    else if (addr == A_POL) rdata = pol_q;
    else if (addr == A_CFG) rdata = cfg_q;
    else                    rdata = '1;
  end

  // R4
  ro_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
  // R5
  bad_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr > A_CFG) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
  // R3
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_OUT) |=> out_q == $past(wdata));
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target #(
  parameter int          DW          = 8,
  parameter int          NPINS       = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [DW-2:0] DEV_ADDR  = 7'b1001001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [NPINS-1:0] pin_lvl,
  output logic [DW-1:0]    out_reg,
  output logic [DW-1:0]    pol_reg,
  output logic [DW-1:0]    cfg_reg,
  output logic [DW-1:0]    rp_addr,
  output logic             rp_wr,
  output logic [DW-1:0]    rp_wdata,
  output logic             rp_rd
);
  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] rp_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  gpx_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  gpx_i2c_fsm #(.DW(DW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rp_rdata  (rp_rdata),
    .sda_oe    (sda_oe),
    .rp_addr   (rp_addr),
    .rp_wr     (rp_wr),
    .rp_wdata  (rp_wdata),
    .rp_rd     (rp_rd)
  );

  gpx_regfile #(.DW(DW), .NPINS(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pin_lvl (pin_lvl),
    .addr    (rp_addr),
    .wr      (rp_wr),
    .wdata   (rp_wdata),
    .rdata   (rp_rdata),
    .out_q   (out_reg),
    .pol_q   (pol_reg),
    .cfg_q   (cfg_reg)
  );
endmodule

// File: tb/gpx_i2c_target_tb.sv
module gpx_i2c_target_tb;
  localparam int H = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, mscl, msda;
  logic [3:0] pins;
  logic       sda_oe, rp_wr, rp_rd;
  logic [7:0] out_reg, pol_reg, cfg_reg, rp_addr, rp_wdata;
  wire        sda_bus = msda & ~sda_oe;

  gpx_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(mscl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pin_lvl(pins), .out_reg(out_reg), .pol_reg(pol_reg), .cfg_reg(cfg_reg),
    .rp_addr(rp_addr), .rp_wr(rp_wr), .rp_wdata(rp_wdata), .rp_rd(rp_rd)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, last_drv = 0, wr_seen = 0;
  bit done = 0, cmp_on = 0;
  logic [7:0] m_out, m_pol, m_cfg, m_ptr;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // per-clock reference comparison of the register file (R3 R4 R5 R10)
  always @(negedge clk) begin
    cyc++;
    if (rp_wr) wr_seen++;
    if (cmp_on && (cyc - last_drv) > 8) begin
      chk("R3 out_reg vs model", out_reg, m_out);
      chk("R3 pol_reg vs model", pol_reg, m_pol);
      chk("R3 cfg_reg vs model", cfg_reg, m_cfg);
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    case (p)
      8'd0: return {4'hF, pins ^ m_pol[3:0]};
      8'd1: return m_out;
      8'd2: return m_pol;
      8'd3: return m_cfg;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv_scl(input logic v);
    mscl = v;
    last_drv = cyc;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_out = 8'hFF; m_pol = 8'h00; m_cfg = 8'hFF; m_ptr = 8'h00;
    last_drv = cyc;
    tick(5);
    rst_n = 1'b1;
    last_drv = cyc;
    tick(4);
  endtask

  task automatic model_wr(input logic [7:0] b);
    case (m_ptr)
      8'd1: m_out = b;
      8'd2: m_pol = b;
      8'd3: m_cfg = b;
      default: ;
    endcase
  endtask

  task automatic bus_start();
    msda = 1'b1; tick(H);
    drv_scl(1'b1); tick(H);
    msda = 1'b0; tick(H);
    drv_scl(1'b0); tick(H);
  endtask

  task automatic bus_stop();
    msda = 1'b0; tick(H);
    drv_scl(1'b1); tick(H);
    msda = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      msda = v[7-i]; tick(H);
      drv_scl(1'b1); tick(H);
      drv_scl(1'b0);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit wdat, output bit acked);
    send_bits(b, 8);
    if (wdat) model_wr(b);
    msda = 1'b1; tick(H);
    drv_scl(1'b1); tick(H/2);
    acked = sda_oe;
    tick(H/2);
    drv_scl(1'b0);
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      msda = 1'b1; tick(H);
      drv_scl(1'b1); tick(H/2);
      d[i] = sda_bus;
      tick(H/2);
      drv_scl(1'b0);
    end
    msda = mack ? 1'b0 : 1'b1; tick(H);
    drv_scl(1'b1); tick(H);
    drv_scl(1'b0);
    tick(2);
    msda = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    bit a;
    int w0;
    logic [7:0] d;
    msda = 1'b1; mscl = 1'b1; pins = 4'b1010;
    do_reset();
    cmp_on = 1;
    chk("R10 reset out", out_reg, 8'hFF);
    chk("R10 reset pol", pol_reg, 8'h00);
    chk("R10 reset cfg", cfg_reg, 8'hFF);
    chk("R10 reset sda released", sda_oe, 0);

    // R1 wrong address, bus ignored until START
    w0 = wr_seen;
    bus_start();
    send_byte(8'h94, 0, a); chk("R1 wrong addr nack", a, 0);
    send_byte(8'h02, 0, a); chk("R1 ignored byte nack", a, 0);
    send_byte(8'h33, 0, a); chk("R1 ignored byte2 nack", a, 0);
    bus_stop();
    chk("R1 no strobe after mismatch", wr_seen, w0);

    // R2 R3 single write to output register
    bus_start();
    send_byte(8'h92, 0, a); chk("R1 addr ack", a, 1);
    send_byte(8'h01, 0, a); chk("R2 cmd ack", a, 1); m_ptr = 8'h01;
    chk("R2 no strobe for cmd", wr_seen, w0);
    send_byte(8'h5A, 1, a); chk("R3 data ack", a, 1);
    bus_stop();
    chk("R3 one strobe", wr_seen, w0 + 1);
    chk("R3 out written", out_reg, 8'h5A);

    // R3 two bytes in one transfer to polarity
    w0 = wr_seen;
    bus_start();
    send_byte(8'h92, 0, a);
    send_byte(8'h02, 0, a); m_ptr = 8'h02;
    send_byte(8'h0F, 1, a); chk("R3 first of two ack", a, 1);
    send_byte(8'h03, 1, a); chk("R3 second of two ack", a, 1);
    bus_stop();
    chk("R3 two strobes", wr_seen, w0 + 2);
    chk("R3 pol last byte wins", pol_reg, 8'h03);

    // R4 write to input register ignored
    bus_start();
    send_byte(8'h92, 0, a);
    send_byte(8'h00, 0, a); m_ptr = 8'h00;
    send_byte(8'h12, 1, a); chk("R4 ro write ack", a, 1);
    bus_stop();
    chk("R4 out unchanged", out_reg, 8'h5A);
    chk("R4 pol unchanged", pol_reg, 8'h03);
    chk("R4 cfg unchanged", cfg_reg, 8'hFF);

    // R5 pointer above 3
    bus_start();
    send_byte(8'h92, 0, a);
    send_byte(8'h07, 0, a); chk("R5 cmd7 ack", a, 1); m_ptr = 8'h07;
    send_byte(8'h00, 1, a); chk("R5 data ack", a, 1);
    bus_start();
    send_byte(8'h93, 0, a); chk("R5 read addr ack", a, 1);
    recv_byte(d, 0); chk("R5 read FFh", d, 8'hFF);
    bus_stop();

    // R8 R6 R7 input read with inversion, three bytes
    bus_start();
    send_byte(8'h92, 0, a);
    send_byte(8'h00, 0, a); m_ptr = 8'h00;
    bus_start();
    send_byte(8'h93, 0, a);
    recv_byte(d, 1); chk("R8 input xor pol", d, exp_rd(8'h00));
    recv_byte(d, 1); chk("R6 second byte same reg", d, 8'hF9);
    recv_byte(d, 0); chk("R6 third byte same reg", d, 8'hF9);
    tick(6);
    chk("R7 released after nack", sda_oe, 0);
    bus_stop();

    // R6 pointer persists across transfers
    pins = 4'b0101;
    bus_start();
    send_byte(8'h93, 0, a);
    recv_byte(d, 0); chk("R6 persisted pointer", d, 8'hF6);
    bus_stop();

    // R7 direction register write and readback
    bus_start();
    send_byte(8'h92, 0, a);
    send_byte(8'h03, 0, a); m_ptr = 8'h03;
    send_byte(8'hF0, 1, a);
    bus_start();
    send_byte(8'h93, 0, a);
    recv_byte(d, 1); chk("R7 cfg readback", d, 8'hF0);
    recv_byte(d, 0); chk("R6 cfg repeat", d, 8'hF0);
    bus_stop();

    // R9 STOP mid byte
    bus_start();
    send_byte(8'h92, 0, a);
    send_byte(8'h01, 0, a); m_ptr = 8'h01;
    send_bits(8'h00, 4);
    bus_stop();
    chk("R9 partial byte not written", out_reg, 8'h5A);
    chk("R9 sda released", sda_oe, 0);
    bus_start();
    send_byte(8'h93, 0, a); chk("R9 next transfer ack", a, 1);
    recv_byte(d, 0); chk("R9 next transfer data", d, 8'h5A);
    bus_stop();

    // R11 repeated START mid data byte
    bus_start();
    send_byte(8'h92, 0, a);
    send_byte(8'h02, 0, a); m_ptr = 8'h02;
    send_bits(8'hA0, 3);
    bus_start();
    send_byte(8'h93, 0, a); chk("R11 restart addr ack", a, 1);
    recv_byte(d, 0); chk("R11 partial byte dropped", d, 8'h03);
    bus_stop();

    // R10 reset during a transfer
    bus_start();
    send_byte(8'h92, 0, a);
    send_byte(8'h01, 0, a);
    send_bits(8'h00, 4);
    do_reset();
    chk("R10 mid reset out", out_reg, 8'hFF);
    chk("R10 mid reset pol", pol_reg, 8'h00);
    chk("R10 mid reset sda", sda_oe, 0);
    bus_stop();
    bus_start();
    send_byte(8'h93, 0, a);
    recv_byte(d, 0); chk("R10 pointer back to 0", d, 8'hF5);
    bus_stop();

    tick(20);
    done = 1;
    finish_run();
  end
endmodule